// File: doc/BRIEF.md
# Dual-ALU Integer Issue Queue

This block holds decoded integer instructions until their source operands are available, then hands them out of order to two integer ALUs. Decode writes up to four instructions per cycle into free slots. Each slot keeps a class code, a function code, an immediate, three physical source register numbers with one ready flag each, and a branch mask. Result buses from the register file write ports carry up to three destination register numbers per cycle. Any waiting source that matches one of them becomes ready.

Each cycle the queue picks at most one instruction for each ALU. The first ALU accepts generic operations and branch/shift operations. The second ALU accepts generic operations, multiplies and divides. A divide keeps the second ALU occupied for a parameterised number of cycles. When several instructions compete, the oldest one wins. A slot is released the moment its instruction issues. A mispredicted branch removes every instruction whose branch mask overlaps the kill mask. A full flag tells decode to stall while fewer than four slots are free.

Top module: `iq_int_dual_alu`

## Requirements
- R1: After reset the queue is empty: neither ALU port issues, and `full` is 0.
- R2: An instruction written with `wr_valid` in one cycle, with all sources ready, is offered for issue in the following cycle and not earlier.
- R3: A source's ready flag at write time is `wr_src_rdy`, or 1 if a valid result bus carries the same register number in that same write cycle.
- R4: A waiting source becomes ready when a result bus with `wb_valid` set carries its register number. The instruction can issue in the cycle after that broadcast, and not in the broadcast cycle. A bus with `wb_valid` clear wakes nothing.
- R5: Class codes are 0 = generic, 1 = branch/shift, 2 = multiply, 3 = divide. ALU port 0 issues only classes 0 and 1, and ALU port 1 issues only classes 0, 2 and 3.
- R6: Among eligible instructions, port 0 takes the oldest one it may accept. Port 1 takes the oldest remaining one it may accept. Within one write cycle, a lower write lane is older.
- R7: An instruction issues exactly once; its slot is freed in its issue cycle.
- R8: After a divide issues on port 1, port 1 issues nothing for the next DIV_LAT-1 cycles, while port 0 continues to issue.
- R9: When `kill_valid` is set, every held instruction whose branch mask overlaps `kill_mask` is removed and never issues, including one that would have issued in that cycle. An instruction written in that cycle with an overlapping mask is dropped.
- R10: `full` is 1 while fewer than four slots are free. While `full` is 1, writes are ignored.
- R11: An issuing port presents the instruction's function code, immediate and three source register numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 4 | Write lane valid |
| wr_cls | input | 4x2 | Class code per lane |
| wr_func | input | 4x6 | Function code per lane |
| wr_imm | input | 4x16 | Immediate per lane |
| wr_src | input | 4x3x6 | Source register numbers per lane |
| wr_src_rdy | input | 4x3 | Source ready flags from the busy table |
| wr_bmask | input | 4x4 | Branch mask per lane |
| wb_valid | input | 3 | Result bus valid |
| wb_preg | input | 3x6 | Result bus destination register number |
| kill_valid | input | 1 | Mispredict kill strobe |
| kill_mask | input | 4 | Branch bits being killed |
| full | output | 1 | Fewer than four free slots |
| iss_valid | output | 2 | Issue valid per ALU port |
| iss_func | output | 2x6 | Issued function code |
| iss_imm | output | 2x16 | Issued immediate |
| iss_src | output | 2x3x6 | Issued source register numbers |

## Verification
The slot state is observable only through what issues and when, so each kind of corruption has its own signature at the ports.
- A broken age relation shows up as the wrong instruction id on a port in the first cycle where two candidates compete.
- A stuck or early ready flag shifts an issue by one cycle around a broadcast.
- A lost or surviving valid bit makes an instruction vanish, issue twice, or appear after a kill.
- A wrong divide counter changes the length of the port-1 gap.

The directed scenarios therefore compare the issued immediate, used as an id, on both ports cycle by cycle around each of these events.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int NWR     = 4;   // write lanes per cycle
    localparam int NSRC    = 3;   // source operands per instruction
    localparam int NWB     = 3;   // result buses
    localparam int NALU    = 2;   // issue ports
    localparam int PREG_W  = 6;
    localparam int FUNC_W  = 6;
    localparam int IMM_W   = 16;
    localparam int BMASK_W = 4;
    localparam int CLS_W   = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ANY  = 2'd0,
        CLS_ALU1 = 2'd1,
        CLS_MUL  = 2'd2,
        CLS_DIV  = 2'd3
    } iq_cls_e;

    typedef struct packed {
        iq_cls_e                      cls;
        logic [FUNC_W-1:0]            func;
        logic [IMM_W-1:0]             imm;
        logic [NSRC-1:0][PREG_W-1:0]  src;
        logic [NSRC-1:0]              rdy;
        logic [BMASK_W-1:0]           bmask;
    } iq_entry_t;
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup
    import iq_pkg::*;
(
    input  logic [NSRC-1:0][PREG_W-1:0] src,
    input  logic [NSRC-1:0]             rdy_in,
    input  logic [NWB-1:0]              wb_valid,
    input  logic [NWB-1:0][PREG_W-1:0]  wb_preg,
    output logic [NSRC-1:0]             rdy_out
);
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            rdy_out[s] = rdy_in[s];
            for (int b = 0; b < NWB; b++) begin
                if (wb_valid[b] && (wb_preg[b] == src[s])) begin
                    rdy_out[s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int N = 16,
    parameter int K = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            free_mask,
    output logic [K-1:0][IDX_W-1:0] slot_idx
);
    // lane k receives the k-th lowest free slot
    always_comb begin
        int cnt;
        cnt = 0;
        slot_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (free_mask[i] && (cnt < K)) begin
                slot_idx[cnt] = IDX_W'(i);
                cnt = cnt + 1;
            end
        end
    end
endmodule

// File: rtl/iq_oldest.sv
module iq_oldest #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]          cand,
    input  logic [N-1:0][N-1:0]   elder,  // elder[i][j]: slot j is older than slot i
    output logic [N-1:0]          grant,
    output logic [IDX_W-1:0]      idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && !(|(elder[i] & cand))) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iq_int_dual_alu.sv
module iq_int_dual_alu
    import iq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DIV_LAT = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NWR-1:0]                     wr_valid,
    input  logic [NWR-1:0][CLS_W-1:0]          wr_cls,
    input  logic [NWR-1:0][FUNC_W-1:0]         wr_func,
    input  logic [NWR-1:0][IMM_W-1:0]          wr_imm,
    input  logic [NWR-1:0][NSRC-1:0][PREG_W-1:0] wr_src,
    input  logic [NWR-1:0][NSRC-1:0]           wr_src_rdy,
    input  logic [NWR-1:0][BMASK_W-1:0]        wr_bmask,
    input  logic [NWB-1:0]                     wb_valid,
    input  logic [NWB-1:0][PREG_W-1:0]         wb_preg,
    input  logic                               kill_valid,
    input  logic [BMASK_W-1:0]                 kill_mask,
    output logic                               full,
    output logic [NALU-1:0]                    iss_valid,
    output logic [NALU-1:0][FUNC_W-1:0]        iss_func,
    output logic [NALU-1:0][IMM_W-1:0]         iss_imm,
    output logic [NALU-1:0][NSRC-1:0][PREG_W-1:0] iss_src
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DIV_LAT + 1);
    localparam int FCW   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        iq_entry_t [DEPTH-1:0]        ent;
        logic [DEPTH-1:0][DEPTH-1:0]  elder;
        logic [CNT_W-1:0]             div_cnt;
    } iq_state_t;

    iq_state_t st_d, st_q;

    logic [DEPTH-1:0][NSRC-1:0] ent_rdy_wk;
    logic [NWR-1:0][NSRC-1:0]   new_rdy_wk;
    logic [NWR-1:0][IDX_W-1:0]  slot_idx;
    logic [DEPTH-1:0]           kill_hit, elig, cand1, cand2, g1, g2;
    logic [IDX_W-1:0]           idx1, idx2;
    logic [NWR-1:0]             wr_kill;
    logic [DEPTH-1:0]           new_mask;
    logic [FCW-1:0]             free_cnt;
    logic                       div_busy;
    iq_entry_t                  e1, e2;

    // wakeup of held operands and of operands arriving this cycle
    for (genvar i = 0; i < DEPTH; i++) begin : g_wk_ent
        iq_wakeup u_wk (
            .src     (st_q.ent[i].src),
            .rdy_in  (st_q.ent[i].rdy),
            .wb_valid(wb_valid),
            .wb_preg (wb_preg),
            .rdy_out (ent_rdy_wk[i])
        );
    end
    for (genvar k = 0; k < NWR; k++) begin : g_wk_new
        iq_wakeup u_wk (
            .src     (wr_src[k]),
            .rdy_in  (wr_src_rdy[k]),
            .wb_valid(wb_valid),
            .wb_preg (wb_preg),
            .rdy_out (new_rdy_wk[k])
        );
    end

    iq_alloc #(.N(DEPTH), .K(NWR)) u_alloc (
        .free_mask(~st_q.vld),
        .slot_idx (slot_idx)
    );

    // candidate masks for the two ports
    assign div_busy = (st_q.div_cnt != '0);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            kill_hit[i] = kill_valid && (|(st_q.ent[i].bmask & kill_mask));
            elig[i]     = st_q.vld[i] && (&st_q.ent[i].rdy) && !kill_hit[i];
            cand1[i]    = elig[i] && ((st_q.ent[i].cls == CLS_ANY) ||
                                      (st_q.ent[i].cls == CLS_ALU1));
        end
    end

    iq_oldest #(.N(DEPTH)) u_pick1 (
        .cand (cand1),
        .elder(st_q.elder),
        .grant(g1),
        .idx  (idx1)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand2[i] = elig[i] && !g1[i] && !div_busy &&
                       (st_q.ent[i].cls != CLS_ALU1);
        end
    end

    iq_oldest #(.N(DEPTH)) u_pick2 (
        .cand (cand2),
        .elder(st_q.elder),
        .grant(g2),
        .idx  (idx2)
    );

    // issue ports
    assign e1 = st_q.ent[idx1];
    assign e2 = st_q.ent[idx2];

    always_comb begin
        iss_valid[0] = |g1;
        iss_valid[1] = |g2;
        iss_func[0]  = e1.func;
        iss_func[1]  = e2.func;
        iss_imm[0]   = e1.imm;
        iss_imm[1]   = e2.imm;
        iss_src[0]   = e1.src;
        iss_src[1]   = e2.src;
    end

    // occupancy
    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            free_cnt = free_cnt + FCW'(!st_q.vld[i]);
        end
    end
    assign full = (free_cnt < FCW'(NWR));

    // next state
    always_comb begin
        st_d     = st_q;
        new_mask = '0;

        for (int i = 0; i < DEPTH; i++) begin
            st_d.ent[i].rdy = ent_rdy_wk[i];
            if (g1[i] || g2[i] || kill_hit[i]) begin
                st_d.vld[i] = 1'b0;
            end
        end

        if ((|g2) && (e2.cls == CLS_DIV)) begin
            st_d.div_cnt = CNT_W'(DIV_LAT - 1);
        end else if (div_busy) begin
            st_d.div_cnt = st_q.div_cnt - 1'b1;
        end

        for (int k = 0; k < NWR; k++) begin
            wr_kill[k] = kill_valid && (|(wr_bmask[k] & kill_mask));
        end

        if (!full) begin
            for (int k = 0; k < NWR; k++) begin
                if (wr_valid[k] && !wr_kill[k]) begin
                    st_d.vld[slot_idx[k]]       = 1'b1;
                    st_d.ent[slot_idx[k]].cls   = iq_cls_e'(wr_cls[k]);
                    st_d.ent[slot_idx[k]].func  = wr_func[k];
                    st_d.ent[slot_idx[k]].imm   = wr_imm[k];
                    st_d.ent[slot_idx[k]].src   = wr_src[k];
                    st_d.ent[slot_idx[k]].rdy   = new_rdy_wk[k];
                    st_d.ent[slot_idx[k]].bmask = wr_bmask[k];
                    for (int x = 0; x < DEPTH; x++) begin
                        st_d.elder[x][slot_idx[k]] = 1'b0;
                    end
                    st_d.elder[slot_idx[k]] = st_q.vld | new_mask;
                    new_mask[slot_idx[k]]   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // assertions
    p_port0_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> ((e1.cls == CLS_ANY) || (e1.cls == CLS_ALU1)));

    p_port1_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> (e2.cls != CLS_ALU1));

    p_operands_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> (&e1.rdy));

    p_pick_exists_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand1) |-> iss_valid[0]);

    p_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&iss_valid) |-> (idx1 != idx2));

    p_freed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |=> !st_q.vld[$past(idx1)]);

    p_div_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[1] && (e2.cls == CLS_DIV)) |=> !iss_valid[1]);

    p_no_killed_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_valid && iss_valid[0]) |-> !(|(e1.bmask & kill_mask)));
endmodule

// File: tb/test_iq_int_dual_alu.sv
module test_iq_int_dual_alu;
    import iq_pkg::*;

    logic clk = 1'b0;
    logic rst_n;
    logic [NWR-1:0]                       wr_valid;
    logic [NWR-1:0][CLS_W-1:0]            wr_cls;
    logic [NWR-1:0][FUNC_W-1:0]           wr_func;
    logic [NWR-1:0][IMM_W-1:0]            wr_imm;
    logic [NWR-1:0][NSRC-1:0][PREG_W-1:0] wr_src;
    logic [NWR-1:0][NSRC-1:0]             wr_src_rdy;
    logic [NWR-1:0][BMASK_W-1:0]          wr_bmask;
    logic [NWB-1:0]                       wb_valid;
    logic [NWB-1:0][PREG_W-1:0]           wb_preg;
    logic                                 kill_valid;
    logic [BMASK_W-1:0]                   kill_mask;
    logic                                 full;
    logic [NALU-1:0]                      iss_valid;
    logic [NALU-1:0][FUNC_W-1:0]          iss_func;
    logic [NALU-1:0][IMM_W-1:0]           iss_imm;
    logic [NALU-1:0][NSRC-1:0][PREG_W-1:0] iss_src;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    iq_int_dual_alu #(.DEPTH(16), .DIV_LAT(8)) i_iq_int_dual_alu (.*);

    always #5 clk = ~clk;

    task automatic idle();
        wr_valid   = '0;
        wr_cls     = '0;
        wr_func    = '0;
        wr_imm     = '0;
        wr_src     = '0;
        wr_src_rdy = '0;
        wr_bmask   = '0;
        wb_valid   = '0;
        wb_preg    = '0;
        kill_valid = 1'b0;
        kill_mask  = '0;
    endtask

    // start of a cycle window: inputs set here are captured at the next rising edge
    task automatic win();
        @(negedge clk);
        idle();
    endtask

    task automatic put(input int k, input iq_cls_e cls, input int id, input int mask,
                       input int p0, input bit r0);
        wr_valid[k]      = 1'b1;
        wr_cls[k]        = cls;
        wr_func[k]       = FUNC_W'(id + 5);
        wr_imm[k]        = IMM_W'(id);
        wr_src[k][0]     = PREG_W'(p0);
        wr_src[k][1]     = PREG_W'(1);
        wr_src[k][2]     = PREG_W'(2);
        wr_src_rdy[k][0] = r0;
        wr_src_rdy[k][1] = 1'b1;
        wr_src_rdy[k][2] = 1'b1;
        wr_bmask[k]      = BMASK_W'(mask);
    endtask

    task automatic wake(input int port, input int preg);
        wb_valid[port] = 1'b1;
        wb_preg[port]  = PREG_W'(preg);
    endtask

    task automatic chk(input string req, input int port, input bit ev, input int eid);
        n_tests++;
        if (iss_valid[port] !== ev || (ev && iss_imm[port] !== IMM_W'(eid))) begin
            n_fail++;
            $display("FAIL %s port%0d: actual valid=%0b id=%0d, expected valid=%0b id=%0d",
                     req, port, iss_valid[port], iss_imm[port], ev, eid);
        end
    endtask

    task automatic chk_none(input string req);
        chk(req, 0, 1'b0, 0);
        chk(req, 1, 1'b0, 0);
    endtask

    task automatic chk_full(input string req, input bit ef);
        n_tests++;
        if (full !== ef) begin
            n_fail++;
            $display("FAIL %s full: actual %0b expected %0b", req, full, ef);
        end
    endtask

    task automatic t_reset();
        win(); #1;
        chk_none("R1");
        chk_full("R1", 1'b0);
    endtask

    task automatic t_basic();
        win(); put(0, CLS_ANY, 1, 0, 3, 1'b1); #1;
        chk_none("R2");
        win(); #1;
        chk("R2", 0, 1'b1, 1);
        chk("R2", 1, 1'b0, 0);
        n_tests++;
        if (iss_func[0] !== FUNC_W'(6) || iss_src[0][0] !== PREG_W'(3) ||
            iss_src[0][1] !== PREG_W'(1) || iss_src[0][2] !== PREG_W'(2)) begin
            n_fail++;
            $display("FAIL R11: actual func=%0d src=%0d/%0d/%0d expected 6 3/1/2",
                     iss_func[0], iss_src[0][0], iss_src[0][1], iss_src[0][2]);
        end
        win(); #1;
        chk_none("R7");
    endtask

    task automatic t_class();
        win(); put(0, CLS_MUL, 2, 0, 3, 1'b1); put(1, CLS_ALU1, 3, 0, 3, 1'b1);
        win(); #1;
        chk("R5", 0, 1'b1, 3);
        chk("R5", 1, 1'b1, 2);
        win(); put(0, CLS_MUL, 4, 0, 3, 1'b1); put(1, CLS_MUL, 5, 0, 3, 1'b1);
        win(); #1;
        chk("R5", 0, 1'b0, 0);
        chk("R6", 1, 1'b1, 4);
        win(); #1;
        chk("R6", 1, 1'b1, 5);
        win(); #1;
        chk_none("R7");
    endtask

    task automatic t_wake();
        win(); put(0, CLS_ANY, 6, 0, 7, 1'b0);
        win(); #1;
        chk_none("R3");
        win(); wake(2, 7); #1;
        chk_none("R4");
        win(); #1;
        chk("R4", 0, 1'b1, 6);
        // same-cycle bypass at write time
        win(); put(0, CLS_ANY, 7, 0, 9, 1'b0); wake(0, 9);
        win(); #1;
        chk("R3", 0, 1'b1, 7);
        // a bus without its valid wakes nothing
        win(); put(0, CLS_ANY, 8, 0, 11, 1'b0);
        win(); wb_preg[1] = PREG_W'(11);
        win(); #1;
        chk_none("R4");
        wake(1, 11);
        win(); #1;
        chk("R4", 0, 1'b1, 8);
    endtask

    task automatic t_age();
        win(); put(2, CLS_ANY, 10, 0, 20, 1'b0);
        win(); put(0, CLS_ANY, 11, 0, 20, 1'b0); put(1, CLS_ANY, 12, 0, 20, 1'b0);
        win(); wake(1, 20); #1;
        chk_none("R4");
        win(); #1;
        chk("R6", 0, 1'b1, 10);
        chk("R6", 1, 1'b1, 11);
        win(); #1;
        chk("R6", 0, 1'b1, 12);
        chk("R6", 1, 1'b0, 0);
        win(); #1;
        chk_none("R7");
    endtask

    task automatic t_div();
        win(); put(0, CLS_DIV, 20, 0, 3, 1'b1); put(1, CLS_MUL, 21, 0, 3, 1'b1);
        win(); #1;
        chk("R8", 1, 1'b1, 20);
        chk("R5", 0, 1'b0, 0);
        for (int n = 1; n <= 7; n++) begin
            win();
            if (n == 2) put(0, CLS_ANY, 22, 0, 3, 1'b1);
            #1;
            chk("R8", 1, 1'b0, 0);
            chk("R8", 0, (n == 3), 22);
        end
        win(); #1;
        chk("R8", 1, 1'b1, 21);
        win(); #1;
        chk_none("R7");
    endtask

    task automatic t_kill();
        win(); put(0, CLS_ANY, 30, 1, 30, 1'b0); put(1, CLS_ANY, 31, 2, 30, 1'b0);
        win(); kill_valid = 1'b1; kill_mask = 4'b0001; wake(0, 30);
               put(0, CLS_ANY, 32, 1, 3, 1'b1); #1;
        chk_none("R9");
        win(); #1;
        chk("R9", 0, 1'b1, 31);
        chk("R9", 1, 1'b0, 0);
        win(); #1;
        chk_none("R9");
        win(); put(0, CLS_ANY, 33, 4, 3, 1'b1);
        win(); kill_valid = 1'b1; kill_mask = 4'b0100; #1;
        chk_none("R9");
        win(); #1;
        chk_none("R9");
    endtask

    task automatic t_full();
        for (int c = 0; c < 4; c++) begin
            win();
            for (int k = 0; k < 4; k++) put(k, CLS_ANY, 50 + 4 * c + k, 0, 40, 1'b0);
            #1;
            if (c == 3) chk_full("R10", 1'b0);
        end
        win(); put(0, CLS_ANY, 99, 0, 3, 1'b1); #1;
        chk_full("R10", 1'b1);
        win(); wake(2, 40); #1;
        chk_none("R10");
        chk_full("R10", 1'b1);
        for (int n = 0; n < 8; n++) begin
            win(); #1;
            chk("R6", 0, 1'b1, 50 + 2 * n);
            chk("R6", 1, 1'b1, 51 + 2 * n);
            if (n < 2) chk_full("R10", 1'b1);
            if (n == 2) chk_full("R10", 1'b0);
        end
        win(); #1;
        chk_none("R10");
        chk_full("R10", 1'b0);
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_class();
        t_wake();
        t_age();
        t_div();
        t_kill();
        t_full();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule